// File: doc/BRIEF.md
# Redundant Parameter Page Integrity Checker

This block watches a byte stream that carries several back-to-back copies of a flash parameter page, each copy a fixed size (256 bytes by default). For every copy it runs a 16-bit CRC over the body of the copy. It compares that CRC with the value stored in the last two bytes. It also checks the four-byte signature at the head of the copy and the invalid marker in the revision field. Each copy gets a pass or fail verdict, reported together with the copy number and the computed CRC.

The first copy that passes is selected. Its index is then held until a new page stream begins, and any later copies are ignored. If every copy up to the configured count fails, an error flag is raised instead. A start-of-page marker on the first byte restarts the evaluation at copy 0. Bytes arrive one per clock while the valid input is high, and idle cycles may be inserted anywhere in the stream.

Top module: `pp_guard`

## Requirements
- R1: The CRC of a copy uses polynomial 8005h and seed 4F4Eh. Each byte is fed MSB first, with no reflection and no final XOR. The CRC covers the copy's bytes 0 to 253. The value reported on `copy_crc` is this CRC for the copy named by `copy_idx`.
- R2: The stored CRC is taken from byte 254 (low half) and byte 255 (high half) of the copy. A copy whose stored CRC differs from the computed CRC fails.
- R3: Bytes 0, 1, 2 and 3 of a copy must be 4Fh, 4Eh, 46h and 49h. Any other value in any of them fails the copy.
- R4: A copy whose byte 4 has bit 0 set fails, even when its CRC and signature are correct.
- R5: `copy_done` is high for exactly one cycle, in the cycle after the last byte of an evaluated copy is accepted. In that cycle `copy_pass` and `copy_idx` carry that copy's verdict and index.
- R6: When a copy passes, `sel_valid` rises with `sel_idx` set to that copy's index. No later copy is evaluated. Both outputs hold until the next start-of-page byte.
- R7: A failing copy moves evaluation on to the next copy. `all_fail` rises only when copy NUM_COPIES-1 fails. `all_fail` and `sel_valid` are never high together.
- R8: Cycles with `in_valid` low have no effect. A stream with idle gaps gives the same verdicts and CRCs as the same stream sent without gaps.
- R9: A byte with `in_valid` and `in_sop` both high is taken as byte 0 of copy 0, even in the middle of a stream. It clears `sel_valid` and `all_fail`.
- R10: Bytes received after reset but before any start-of-page byte are ignored. Bytes received after a final verdict are also ignored, until the next start-of-page byte. Neither case produces `copy_done`.
- R11: After reset, `copy_done`, `sel_valid` and `all_fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_sop | input | 1 | This byte is the first byte of the page stream |
| in_data | input | 8 | Stream byte |
| copy_done | output | 1 | One-cycle pulse per evaluated copy |
| copy_pass | output | 1 | Verdict of the copy just evaluated |
| copy_idx | output | IDXW | Index of the copy just evaluated |
| copy_crc | output | 16 | CRC computed over that copy's bytes 0..253 |
| sel_valid | output | 1 | A passing copy has been selected |
| sel_idx | output | IDXW | Index of the selected copy |
| all_fail | output | 1 | Every copy up to NUM_COPIES-1 failed |

## Verification
The bench builds the block with its default values: three copies of 256 bytes each. With three copies, a stream can fail on copy 0 and copy 1 and be rescued by copy 2. The bench also covers a stream where all three copies fail and the error flag is raised. Each copy size of 256 bytes puts the stored CRC bytes at positions 254 and 255. The bench computes the expected CRC with its own shift-register form of the polynomial division. It then compares `copy_crc` against that value for passing copies and for failing ones.

// File: rtl/pp_guard_pkg.sv
package pp_guard_pkg;

   localparam logic [15:0] PP_CRC_POLY = 16'h8005;
   localparam logic [15:0] PP_CRC_SEED = 16'h4F4E;
   localparam int          PP_SIG_LEN  = 4;

   // Signature byte expected at position k of every copy
   function automatic logic [7:0] sig_byte(input logic [1:0] k);
      case (k)
         2'd0:    sig_byte = 8'h4F;
         2'd1:    sig_byte = 8'h4E;
         2'd2:    sig_byte = 8'h46;
         default: sig_byte = 8'h49;
      endcase
   endfunction

endpackage

// File: rtl/pp_byte_tracker.sv
module pp_byte_tracker #(
   parameter int COPY_BYTES = 256,
   parameter int NUM_COPIES = 3,
   localparam int POSW = $clog2(COPY_BYTES),
   localparam int IDXW = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            beat,
   input  logic            sop,
   output logic [POSW-1:0] cur_pos,
   output logic [IDXW-1:0] cur_copy,
   output logic            last_byte
);
   localparam logic [POSW-1:0] LAST_POS  = POSW'(COPY_BYTES - 1);
   localparam logic [IDXW-1:0] LAST_COPY = IDXW'(NUM_COPIES - 1);

   logic [POSW-1:0] pos_q;
   logic [IDXW-1:0] copy_q;

   assign cur_pos   = sop ? '0 : pos_q;
   assign cur_copy  = sop ? '0 : copy_q;
   assign last_byte = beat && (cur_pos == LAST_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         copy_q <= '0;
      end else if (beat) begin
         pos_q <= cur_pos + 1'b1;
         if (cur_pos == LAST_POS && cur_copy != LAST_COPY)
            copy_q <= cur_copy + 1'b1;
         else
            copy_q <= cur_copy;
      end
   end

   // R7: copy index never walks past the configured count
   p_copy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      copy_q <= LAST_COPY);

   // R8: no byte accepted, no position change
   p_pos_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !beat |=> $stable(pos_q) && $stable(copy_q));

endmodule

// File: rtl/pp_crc_engine.sv
module pp_crc_engine
   import pp_guard_pkg::*;
#(
   parameter int          COPY_BYTES = 256,
   parameter logic [15:0] POLY       = PP_CRC_POLY,
   parameter logic [15:0] SEED       = PP_CRC_SEED,
   localparam int POSW = $clog2(COPY_BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            beat,
   input  logic [POSW-1:0] cur_pos,
   input  logic [7:0]      data,
   output logic [15:0]     crc
);
   localparam logic [POSW-1:0] BODY_END = POSW'(COPY_BYTES - 2);

   logic [15:0] crc_q;
   logic [15:0] stage [0:8];

   assign stage[0] = (cur_pos == '0) ? SEED : crc_q;

   // One shift per input bit, MSB of the byte first
   for (genvar b = 0; b < 8; b++) begin : g_bit
      logic fb;
      assign fb = stage[b][15] ^ data[7-b];
      assign stage[b+1] = {stage[b][14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= SEED;
      else if (beat && cur_pos < BODY_END)
         crc_q <= stage[8];
   end

   assign crc = crc_q;

   // R1: the two stored-CRC bytes never enter the running CRC
   p_tail_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
      beat && cur_pos >= BODY_END |=> $stable(crc_q));

endmodule

// File: rtl/pp_copy_judge.sv
module pp_copy_judge
   import pp_guard_pkg::*;
#(
   parameter int COPY_BYTES = 256,
   localparam int POSW = $clog2(COPY_BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            beat,
   input  logic [POSW-1:0] cur_pos,
   input  logic [7:0]      data,
   input  logic [15:0]     crc_calc,
   output logic            copy_ok
);
   localparam logic [POSW-1:0] LO_POS = POSW'(COPY_BYTES - 2);
   localparam int REV_POS = 4;

   logic       hdr_ok_q;
   logic [7:0] crc_lo_q;
   logic       hdr_base;
   logic       hdr_next;

   assign hdr_base = (cur_pos == '0) ? 1'b1 : hdr_ok_q;

   always_comb begin
      hdr_next = hdr_base;
      if (cur_pos < POSW'(PP_SIG_LEN))
         hdr_next = hdr_base && (data == sig_byte(cur_pos[1:0]));
      else if (cur_pos == POSW'(REV_POS))
         hdr_next = hdr_base && !data[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_ok_q <= 1'b0;
         crc_lo_q <= '0;
      end else if (beat) begin
         hdr_ok_q <= hdr_next;
         if (cur_pos == LO_POS)
            crc_lo_q <= data;
      end
   end

   // Valid only in the cycle the last byte (stored CRC high half) is on data
   assign copy_ok = hdr_ok_q && ({data, crc_lo_q} == crc_calc);

   // R3: a header failure is sticky for the rest of the copy
   p_hdr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      beat && cur_pos > POSW'(REV_POS) && !hdr_ok_q |=> !hdr_ok_q);

endmodule

// File: rtl/pp_guard.sv
module pp_guard
   import pp_guard_pkg::*;
#(
   parameter int          COPY_BYTES = 256,
   parameter int          NUM_COPIES = 3,
   parameter logic [15:0] CRC_POLY   = PP_CRC_POLY,
   parameter logic [15:0] CRC_SEED   = PP_CRC_SEED,
   localparam int POSW = $clog2(COPY_BYTES),
   localparam int IDXW = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            in_sop,
   input  logic [7:0]      in_data,
   output logic            copy_done,
   output logic            copy_pass,
   output logic [IDXW-1:0] copy_idx,
   output logic [15:0]     copy_crc,
   output logic            sel_valid,
   output logic [IDXW-1:0] sel_idx,
   output logic            all_fail
);
   localparam logic [IDXW-1:0] LAST_COPY = IDXW'(NUM_COPIES - 1);

   if (NUM_COPIES < 1) begin : g_bad_count
      $error("pp_guard: NUM_COPIES must be at least 1");
   end
   if (COPY_BYTES < 8 || (1 << POSW) != COPY_BYTES) begin : g_bad_size
      $error("pp_guard: COPY_BYTES must be a power of two, at least 8");
   end

   logic            running_q;
   logic            beat;
   logic            sop_beat;
   logic [POSW-1:0] cur_pos;
   logic [IDXW-1:0] cur_copy;
   logic            last_byte;
   logic [15:0]     crc_calc;
   logic            copy_ok;

   assign sop_beat = in_valid && in_sop;
   assign beat     = in_valid && (in_sop || running_q);

   pp_byte_tracker #(.COPY_BYTES(COPY_BYTES), .NUM_COPIES(NUM_COPIES)) u_track (
      .clk(clk), .rst_n(rst_n), .beat(beat), .sop(in_sop),
      .cur_pos(cur_pos), .cur_copy(cur_copy), .last_byte(last_byte)
   );

   pp_crc_engine #(.COPY_BYTES(COPY_BYTES), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
      .clk(clk), .rst_n(rst_n), .beat(beat), .cur_pos(cur_pos),
      .data(in_data), .crc(crc_calc)
   );

   pp_copy_judge #(.COPY_BYTES(COPY_BYTES)) u_judge (
      .clk(clk), .rst_n(rst_n), .beat(beat), .cur_pos(cur_pos),
      .data(in_data), .crc_calc(crc_calc), .copy_ok(copy_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         copy_done <= 1'b0;
         copy_pass <= 1'b0;
         copy_idx  <= '0;
         copy_crc  <= '0;
         sel_valid <= 1'b0;
         sel_idx   <= '0;
         all_fail  <= 1'b0;
      end else begin
         copy_done <= 1'b0;
         if (sop_beat) begin
            running_q <= 1'b1;
            sel_valid <= 1'b0;
            all_fail  <= 1'b0;
         end
         if (last_byte) begin
            copy_done <= 1'b1;
            copy_pass <= copy_ok;
            copy_idx  <= cur_copy;
            copy_crc  <= crc_calc;
            if (copy_ok) begin
               sel_valid <= 1'b1;
               sel_idx   <= cur_copy;
               running_q <= 1'b0;
            end else if (cur_copy == LAST_COPY) begin
               all_fail  <= 1'b1;
               running_q <= 1'b0;
            end
         end
      end
   end

   // R5: verdict pulse is a single cycle
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      copy_done |=> !copy_done);

   // R6: selection appears only with a passing verdict
   p_sel_from_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_valid) |-> copy_done && copy_pass && sel_idx == copy_idx);

   // R6: selection holds until a new page begins
   p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid && !sop_beat |=> sel_valid && $stable(sel_idx));

   // R7: error only after the final copy failed
   p_fail_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(all_fail) |-> copy_done && !copy_pass && copy_idx == LAST_COPY);

   // R7: error and selection are exclusive
   p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_valid && all_fail));

   // R9: a start-of-page byte clears earlier outcomes
   p_sop_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sop_beat |=> !all_fail && !sel_valid);

   // R10: when idle, no verdict is produced
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !running_q && !sop_beat |=> !copy_done);

endmodule

// File: tb/pp_guard_bench.sv
`timescale 1ns/1ps
module pp_guard_bench;
   localparam int CB  = 256;
   localparam int NC  = 3;
   localparam int TOT = CB * NC;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_sop = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       copy_done, copy_pass, sel_valid, all_fail;
   logic [1:0] copy_idx, sel_idx;
   logic [15:0] copy_crc;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   logic [7:0]  strm    [0:TOT-1];
   logic [15:0] exp_crc [0:NC-1];
   int          done_cnt = 0;
   logic        pass_seen [0:NC-1];
   logic [15:0] crc_seen  [0:NC-1];

   always #2 clk = ~clk;

   pp_guard u_pp_guard (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_data(in_data), .copy_done(copy_done), .copy_pass(copy_pass),
      .copy_idx(copy_idx), .copy_crc(copy_crc), .sel_valid(sel_valid),
      .sel_idx(sel_idx), .all_fail(all_fail)
   );

   always @(negedge clk) begin
      if (rst_n && copy_done) begin
         done_cnt = done_cnt + 1;
         pass_seen[copy_idx] = copy_pass;
         crc_seen[copy_idx]  = copy_crc;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Shift-register division: byte goes into the top, 8 conditional XORs
   function automatic logic [15:0] ref_crc(input int base);
      logic [15:0] c = 16'h4F4E;
      for (int i = 0; i < CB - 2; i++) begin
         c = c ^ {strm[base + i], 8'h00};
         for (int j = 0; j < 8; j++)
            c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
      end
      return c;
   endfunction

   task automatic make_copy(input int k, input int seed, input bit bad_sig,
                            input bit bad_rev, input bit bad_crc);
      int b = k * CB;
      logic [15:0] c;
      strm[b+0] = 8'h4F; strm[b+1] = 8'h4E; strm[b+2] = 8'h46; strm[b+3] = 8'h49;
      if (bad_sig) strm[b+2] = 8'h47;
      strm[b+4] = (8'(seed) & 8'hFE) | {7'd0, bad_rev};
      for (int i = 5; i < CB - 2; i++) strm[b+i] = 8'(i * 7 + seed * 13 + k * 3);
      c = ref_crc(b);
      exp_crc[k]   = c;
      strm[b+CB-2] = c[7:0];
      strm[b+CB-1] = bad_crc ? (c[15:8] ^ 8'h01) : c[15:8];
   endtask

   task automatic send(input int first, input int count, input bit with_sop, input bit stall);
      for (int i = 0; i < count; i++) begin
         if (stall && (i % 5 == 2)) begin
            for (int g = 0; g <= i % 3; g++) begin
               @(negedge clk);
               in_valid = 1'b0;
               in_data  = 8'hA5;
            end
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_sop   = with_sop && (i == 0);
         in_data  = strm[first + i];
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic clear_obs();
      done_cnt = 0;
      for (int k = 0; k < NC; k++) begin
         pass_seen[k] = 1'bx;
         crc_seen[k]  = 16'hxxxx;
      end
   endtask

   task automatic t_reset();
      chk("R11 copy_done after reset", copy_done, 0);
      chk("R11 sel_valid after reset", sel_valid, 0);
      chk("R11 all_fail after reset", all_fail, 0);
   endtask

   task automatic t_pre_sop();
      clear_obs();
      make_copy(0, 1, 0, 0, 0);
      send(0, 200, 0, 0);
      settle();
      chk("R10 no verdict before sop", done_cnt, 0);
      chk("R10 sel_valid before sop", sel_valid, 0);
   endtask

   task automatic t_first_good();
      clear_obs();
      for (int k = 0; k < NC; k++) make_copy(k, 5 + k, 0, 0, 0);
      send(0, CB, 1, 0);
      chk("R5 copy_done right after last byte", copy_done, 1);
      chk("R5 copy_idx of copy 0", copy_idx, 0);
      @(negedge clk);
      chk("R5 copy_done one cycle only", copy_done, 0);
      send(CB, 2 * CB, 0, 0);
      settle();
      chk("R6 only one copy evaluated", done_cnt, 1);
      chk("R6 sel_valid", sel_valid, 1);
      chk("R6 sel_idx", sel_idx, 0);
      chk("R1 crc of copy 0", crc_seen[0], exp_crc[0]);
      send(0, 40, 0, 0);
      settle();
      chk("R10 bytes after verdict ignored", done_cnt, 1);
      chk("R6 selection held", sel_valid, 1);
   endtask

   task automatic t_bad_crc(input bit stall, input string tag);
      clear_obs();
      make_copy(0, 9, 0, 0, 1);
      make_copy(1, 10, 0, 0, 0);
      make_copy(2, 11, 0, 0, 0);
      send(0, TOT, 1, stall);
      settle();
      chk({tag, " copy 0 fails on crc"}, pass_seen[0], 0);
      chk({tag, " computed crc reported on fail"}, crc_seen[0], exp_crc[0]);
      chk({tag, " copy 1 selected"}, sel_idx, 1);
      chk({tag, " sel_valid"}, sel_valid, 1);
      chk({tag, " two copies evaluated"}, done_cnt, 2);
      chk({tag, " crc of copy 1"}, crc_seen[1], exp_crc[1]);
   endtask

   task automatic t_bad_sig();
      clear_obs();
      make_copy(0, 20, 1, 0, 0);
      make_copy(1, 21, 1, 0, 0);
      make_copy(2, 22, 0, 0, 0);
      send(0, TOT, 1, 0);
      settle();
      chk("R3 copy 0 signature fail", pass_seen[0], 0);
      chk("R3 copy 1 signature fail", pass_seen[1], 0);
      chk("R7 fallback to copy 2", sel_idx, 2);
      chk("R7 no error when last passes", all_fail, 0);
      chk("R1 crc of copy 2", crc_seen[2], exp_crc[2]);
   endtask

   task automatic t_bad_rev();
      clear_obs();
      make_copy(0, 30, 0, 1, 0);
      make_copy(1, 31, 0, 0, 0);
      make_copy(2, 32, 0, 0, 0);
      send(0, TOT, 1, 0);
      settle();
      chk("R4 revision bit0 fails copy 0", pass_seen[0], 0);
      chk("R4 copy 1 selected", sel_idx, 1);
   endtask

   task automatic t_all_bad();
      clear_obs();
      make_copy(0, 40, 0, 0, 1);
      make_copy(1, 41, 1, 0, 0);
      make_copy(2, 42, 0, 1, 0);
      send(0, TOT, 1, 0);
      settle();
      chk("R7 all_fail after last copy", all_fail, 1);
      chk("R7 sel_valid low on all fail", sel_valid, 0);
      chk("R7 three copies evaluated", done_cnt, 3);
      make_copy(0, 43, 0, 0, 0);
      send(0, 1, 1, 0);
      chk("R9 sop clears all_fail", all_fail, 0);
   endtask

   task automatic t_restart();
      clear_obs();
      make_copy(0, 50, 0, 0, 1);
      send(0, 100, 1, 0);
      make_copy(0, 51, 0, 0, 0);
      send(0, CB, 1, 0);
      settle();
      chk("R9 restart takes new copy 0", done_cnt, 1);
      chk("R9 restart selects copy 0", sel_idx, 0);
      chk("R9 restart sel_valid", sel_valid, 1);
      chk("R1 crc after restart", crc_seen[0], exp_crc[0]);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_pre_sop();
      t_first_good();
      t_bad_crc(0, "R2");
      t_bad_sig();
      t_bad_rev();
      t_all_bad();
      t_bad_crc(1, "R8");
      t_restart();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule